// File: doc/BRIEF.md
# EEPROM Write-Busy Toggle Status

This block models the read side of a byte-wide parallel EEPROM while the part runs its internal write cycle. A host write that arrives while the part is idle is stored in a small register array and starts a write timer of `WRITE_CYCLES` clock cycles. While that timer runs, the part is busy and `busy` is high.

A read during the busy period does not return array contents. It returns a status byte. Bit 6 of that byte flips on every busy read, so the host can spot the end of the write when two reads in a row agree. Bit 7 carries the complement of bit 7 of the byte being written, which gives a second way to poll for completion. Bits 5 to 0 read as zero. Once the timer expires, reads return stored data again.

Writes that arrive during the busy period are dropped, and they do not extend the timer.

Top module: `eeprom_toggle_status`

## Requirements
- R1: After reset, `rd_data` is 0x00, `busy` is low and every array byte reads 0x00.
- R2: A write is accepted when `wr_en` is high while `busy` is low. It stores `wr_data` at `wr_addr`. `busy` then stays high for exactly `WRITE_CYCLES` cycles, starting in the cycle after the accepting edge.
- R3: `rd_data` is registered. It is updated on the clock edge at which `rd_en` is sampled high, and it holds its value while `rd_en` is low.
- R4: A read while `busy` is low returns the array byte at `rd_addr`.
- R5: A read while `busy` is high returns zero in bits 5 to 0.
- R6: A read while `busy` is high returns in bit 7 the complement of bit 7 of the most recently accepted write data.
- R7: The first busy read after a write is accepted returns bit 6 equal to 0.
- R8: Each later busy read in the same write cycle returns bit 6 inverted relative to the previous busy read, whether or not the reads fall in consecutive cycles.
- R9: A write during the busy period changes no array byte and does not restart or lengthen the busy period.
- R10: A read in the same cycle as an accepted write returns the array byte as it was before that write. Reads after `busy` falls return the new array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one read per cycle |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data or busy status byte |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Every result is due one edge after its stimulus:
- a read sampled at a rising edge shows on `rd_data` right after that edge;
- an accepted write raises `busy` right after its edge and drops it `WRITE_CYCLES` edges later.

The bench drives inputs on falling edges. A reference model updates on each rising edge from the inputs it saw there. The ports are compared on the following falling edge, so each comparison sees exactly one edge's effect.

Directed cases cover:
- the first busy read;
- a write during the busy period to an address that is checked afterwards;
- a read in the same cycle as an accepted write;
- a measured busy length.

// File: rtl/eeprom_toggle_status.sv
module eeprom_toggle_status #(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [7:0]    last_wr;
  logic          tog;
  logic          accept;

  assign busy   = (cnt != '0);
  assign accept = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      last_wr <= '0;
      tog     <= 1'b0;
      rd_data <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (rd_en) rd_data <= busy ? {~last_wr[7], tog, 6'b0} : mem[rd_addr];
      if (accept) begin
        mem[wr_addr] <= wr_data;
        last_wr      <= wr_data;
        cnt          <= CW'(WRITE_CYCLES);
        tog          <= 1'b0;
      end else begin
        if (busy) cnt <= cnt - 1'b1;
        if (busy && rd_en) tog <= ~tog;
      end
    end
  end

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));                                         // R2
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));                                           // R3
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> rd_data[5:0] == 6'b0);                              // R5
  AST_FIRST_TOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && rd_en) |=> !rd_data[6]);                                // R7
  AST_TOG_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && $past(busy && rd_en)) |=> rd_data[6] != $past(rd_data[6])); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || cnt < $past(cnt)));                                  // R9
endmodule

// File: tb/sim_eeprom_toggle_status.sv
module sim_eeprom_toggle_status;
  localparam int AW = 6;
  localparam int WC = 12;

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic busy;

  int checks = 0, failures = 0;

  eeprom_toggle_status #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy));

  always #5 clk = ~clk;

  logic [7:0] m_mem [1<<AW];
  logic [7:0] m_rd, m_last;
  int         m_cnt;
  logic       m_tog, m_first;
  int         m_kind;
  bit         model_on = 0;

  function automatic logic [7:0] status_byte(logic [7:0] lw, logic t);
    return {~lw[7], t, 6'b0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) m_mem[i] = 8'h00;
      m_rd = 0; m_last = 0; m_cnt = 0; m_tog = 0; m_kind = 0; m_first = 0;
    end else begin
      m_kind = 0;
      if (rd_en) begin
        if (m_cnt != 0) begin
          m_rd = status_byte(m_last, m_tog);
          m_kind = m_first ? 3 : 2;
          m_first = 0;
          m_tog = ~m_tog;
        end else begin
          m_rd = m_mem[rd_addr];
          m_kind = 1;
        end
      end
      if (wr_en && m_cnt == 0) begin
        m_mem[wr_addr] = wr_data; m_last = wr_data; m_cnt = WC; m_tog = 0; m_first = 1;
      end else if (m_cnt != 0) m_cnt--;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    chk("R2/R9 busy", busy, m_cnt != 0);
    case (m_kind)
      0: chk("R3 hold", rd_data, m_rd);
      1: chk("R4/R10 idle read", rd_data, m_rd);
      default: begin
        chk("R5 low bits", rd_data[5:0], 0);
        chk("R6 poll bit", rd_data[7], m_rd[7]);
        if (m_kind == 3) chk("R7 first toggle", rd_data[6], 0);
        else chk("R8 toggle", rd_data[6], m_rd[6]);
      end
    endcase
  end

  task automatic step(bit r, logic [AW-1:0] ra, bit w, logic [AW-1:0] wa, logic [7:0] wd);
    @(negedge clk);
    rd_en = r; rd_addr = ra; wr_en = w; wr_addr = wa; wr_data = wd;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed, nb;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 busy", busy, 0);
    model_on = 1;
    step(1, 3, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk); chk("R1 array", rd_data, 0);
    step(1, 3, 1, 3, 8'hA5);
    step(1, 3, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 1, 4, 8'h11);
    step(0, 0, 0, 0, 0);
    repeat (WC) step(0, 0, 0, 0, 0);
    step(1, 4, 0, 0, 0);
    step(1, 3, 0, 0, 0);
    step(0, 0, 1, 9, 8'h3C);
    nb = 0;
    for (int i = 0; i < WC + 4; i++) begin
      step(0, 0, 1, 9, 8'hFF);
      wr_en = 0;
      if (busy) nb++;
    end
    chk("R2 busy length", nb, WC);
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 1), AW'($urandom), ($urandom_range(0, 15) == 0),
           AW'($urandom), 8'($urandom));
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    model_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule